// File: doc/BRIEF.md
# Configuration Host Register Interface

This block gives a byte-wide host processor a small register window next to a device's configuration logic. The window holds a free scratch byte, a control byte, a read-only status byte and a port to the configuration data path. The control byte enables three interrupt sources: a data request from the configuration engine, a bitstream error, and an active-low request from user logic. It also selects whether configuration bytes go to a serial daisy-chain output, and whether a host write of such a byte is held until the serializer has shifted it out.

The host starts an access by raising chip select with the direction, address and write data. It keeps them steady until it sees the one-cycle acknowledge, then drops chip select for at least one cycle. The configuration engine, the bitstream parser and the serializer lie outside the block. They talk to it through single-cycle pulses and level inputs. The combined interrupt is a registered, active-low output.

Top module: `cfg_host_if`

## Requirements
- R1: Address 0 is a scratch byte with no effect on the hardware. A read returns the last byte written, and the value after reset is 0x00.
- R2: Address 1 is the control byte, 0x00 after reset. Bit 0 enables the data-request interrupt, bit 1 the error interrupt, bit 2 the user interrupt, bit 3 daisy output and bit 4 bus hold. Bit 5 is user mode and is also driven on `usr_mode_en`. Bits 7 and 6 always read 0, whatever was written to them.
- R3: A control write changes bit 5 only while `cfg_done` is low. With `cfg_done` high, bit 5 keeps its value and the other control bits still update.
- R4: Every access other than a held data write is acknowledged by `hst_ack` high for exactly one cycle, on the cycle after it is accepted. A new access is accepted only after chip select has been low for at least one cycle.
- R5: Address 2 reads status: bit 0 is the data-request flag, bit 1 the error flag, bit 2 the user request (`usr_irq_n` low) and bit 3 serializer busy. The other bits read 0, and writes to this address are ignored.
- R6: A `cfg_data_req` pulse sets the data-request flag only while `cfg_daisy_mode` is high. Any access to address 3 clears the flag. With control bit 0 set, the flag pulls `hst_irq_n` low.
- R7: A `cfg_bs_err` pulse sets the error flag only while `cfg_active` is high. A status read clears the flag. The flag drives the interrupt only when control bit 1 is set and `cfg_active` is high.
- R8: With control bit 2 set, a low level on `usr_irq_n` pulls `hst_irq_n` low, and releasing it releases the interrupt. With bit 2 clear, `usr_irq_n` has no effect on `hst_irq_n`.
- R9: `hst_irq_n` is high after reset and whenever no enabled source is active. It goes low two cycles after a source pulse or level is applied.
- R10: When control bits 3 and 4 are both set, a write to address 3 is not acknowledged until `ser_done` is seen. The acknowledge follows on the cycle after `ser_done`.
- R11: When bus hold or daisy output is clear, a write to address 3 is acknowledged at once. `ser_start` pulses for that write only when daisy output is set, and serializer busy stays set from that pulse until `ser_done`.
- R12: A write to address 3 drives the byte on `cfg_wr_data` with a one-cycle `cfg_wr_stb` on the cycle after acceptance. A read of address 3 returns `cfg_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_cs | input | 1 | Host chip select |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 2 | Register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid with acknowledge |
| hst_ack | output | 1 | One-cycle transfer acknowledge |
| hst_irq_n | output | 1 | Combined interrupt, active low |
| cfg_done | input | 1 | Configuration finished |
| cfg_active | input | 1 | Device is in configuration mode |
| cfg_daisy_mode | input | 1 | Daisy-chain configuration mode |
| cfg_data_req | input | 1 | Pulse: engine requests or offers a data byte |
| cfg_bs_err | input | 1 | Pulse: bitstream error |
| cfg_rd_data | input | 8 | Byte offered for configuration reads |
| cfg_wr_stb | output | 1 | Strobe for a configuration data byte |
| cfg_wr_data | output | 8 | Configuration data byte |
| usr_irq_n | input | 1 | User logic interrupt request, active low |
| usr_mode_en | output | 1 | User-mode control bit |
| ser_start | output | 1 | Pulse: hand the byte to the serializer |
| ser_done | input | 1 | Pulse: serializer finished the byte |

## Verification
An immediate access is acknowledged, with its read data, one cycle after acceptance. The bench's access task therefore expects the acknowledge at the first falling edge after the accepting rising edge. Interrupt sources take two register stages, so the bench checks that `hst_irq_n` is still high one falling edge after a stimulus and low at the second. For a held data write, the bench confirms over several cycles that no acknowledge arrives. It then expects the acknowledge at the first falling edge after the rising edge that sampled `ser_done`. Strobes are counted at falling edges and compared once the access has completed.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

    localparam logic [1:0] ADDR_SCRATCH = 2'd0;
    localparam logic [1:0] ADDR_CTRL    = 2'd1;
    localparam logic [1:0] ADDR_STATUS  = 2'd2;
    localparam logic [1:0] ADDR_DATA    = 2'd3;

    localparam int CTRL_W = 6;
    localparam int STAT_W = 4;

    // packed from bit 5 down to bit 0
    typedef struct packed {
        logic usr_mode;
        logic bus_hold;
        logic daisy_out;
        logic en_usr;
        logic en_err;
        logic en_req;
    } ctrl_t;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_HOLD    = 2'd1,
        BUS_RELEASE = 2'd2
    } bus_st_e;

endpackage

// File: rtl/chi_bus_ctrl.sv
module chi_bus_ctrl
    import cfg_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic       hold_en,
    input  logic       daisy_en,
    input  logic       ser_done,
    output logic       acc,
    output logic       ack,
    output logic       ser_busy,
    output logic       in_hold
);

    typedef struct packed {
        bus_st_e st;
        logic    ack;
        logic    busy;
    } bus_state_t;

    bus_state_t st_d, st_q;
    logic       data_wr;

    always_comb begin
        st_d    = st_q;
        st_d.ack = 1'b0;
        acc     = 1'b0;
        data_wr = cs && wr && (addr == ADDR_DATA);

        case (st_q.st)
            BUS_IDLE: begin
                if (cs) begin
                    acc = 1'b1;
                    if (data_wr && hold_en) begin
                        st_d.st = BUS_HOLD;
                    end else begin
                        st_d.ack = 1'b1;
                        st_d.st  = BUS_RELEASE;
                    end
                end
            end
            BUS_HOLD: begin
                if (ser_done) begin
                    st_d.ack = 1'b1;
                    st_d.st  = BUS_RELEASE;
                end
            end
            BUS_RELEASE: begin
                if (!cs) begin
                    st_d.st = BUS_IDLE;
                end
            end
            default: st_d.st = BUS_IDLE;
        endcase

        if (ser_done) begin
            st_d.busy = 1'b0;
        end
        if (acc && data_wr && daisy_en) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: BUS_IDLE, ack: 1'b0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack      = st_q.ack;
    assign ser_busy = st_q.busy;
    assign in_hold  = (st_q.st == BUS_HOLD);

endmodule

// File: rtl/chi_regfile.sv
module chi_regfile
    import cfg_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_done,
    input  logic [STAT_W-1:0] status,
    input  logic [DATA_W-1:0] cfg_rd_data,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              ser_start,
    output logic              data_access,
    output logic              status_read
);

    localparam int CTRL_PAD = DATA_W - CTRL_W;
    localparam int STAT_PAD = DATA_W - STAT_W;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rdata;
        logic              wstb;
        logic [DATA_W-1:0] wdata;
        logic              sstart;
    } reg_state_t;

    reg_state_t rf_d, rf_q;
    logic       wr_acc, rd_acc;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        case (addr)
            ADDR_SCRATCH: rd_mux = rf_q.scratch;
            ADDR_CTRL:    rd_mux = {{CTRL_PAD{1'b0}}, rf_q.ctrl};
            ADDR_STATUS:  rd_mux = {{STAT_PAD{1'b0}}, status};
            default:      rd_mux = cfg_rd_data;
        endcase
    end

    always_comb begin
        rf_d        = rf_q;
        rf_d.wstb   = 1'b0;
        rf_d.sstart = 1'b0;
        wr_acc      = acc && wr;
        rd_acc      = acc && !wr;
        data_access = acc && (addr == ADDR_DATA);
        status_read = rd_acc && (addr == ADDR_STATUS);

        if (wr_acc) begin
            case (addr)
                ADDR_SCRATCH: rf_d.scratch = wdata;
                ADDR_CTRL: begin
                    rf_d.ctrl.en_req    = wdata[0];
                    rf_d.ctrl.en_err    = wdata[1];
                    rf_d.ctrl.en_usr    = wdata[2];
                    rf_d.ctrl.daisy_out = wdata[3];
                    rf_d.ctrl.bus_hold  = wdata[4];
                    if (!cfg_done) begin
                        rf_d.ctrl.usr_mode = wdata[5];
                    end
                end
                ADDR_DATA: begin
                    rf_d.wstb   = 1'b1;
                    rf_d.wdata  = wdata;
                    rf_d.sstart = rf_q.ctrl.daisy_out;
                end
                default: ;
            endcase
        end

        if (rd_acc) begin
            rf_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ctrl      = rf_q.ctrl;
    assign rdata     = rf_q.rdata;
    assign wr_stb    = rf_q.wstb;
    assign wr_data   = rf_q.wdata;
    assign ser_start = rf_q.sstart;

endmodule

// File: rtl/chi_irq_ctrl.sv
module chi_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic en_err,
    input  logic en_usr,
    input  logic daisy_mode,
    input  logic cfg_active,
    input  logic data_req,
    input  logic bs_err,
    input  logic usr_irq_n,
    input  logic data_access,
    input  logic status_read,
    output logic irq_n,
    output logic req_flag,
    output logic err_flag,
    output logic usr_pend
);

    typedef struct packed {
        logic req;
        logic err;
        logic usr;
        logic irq_n;
    } irq_state_t;

    irq_state_t ir_d, ir_q;

    always_comb begin
        ir_d     = ir_q;
        ir_d.usr = !usr_irq_n;

        if (data_access) begin
            ir_d.req = 1'b0;
        end
        if (data_req && daisy_mode) begin
            ir_d.req = 1'b1;
        end

        if (status_read) begin
            ir_d.err = 1'b0;
        end
        if (bs_err && cfg_active) begin
            ir_d.err = 1'b1;
        end

        ir_d.irq_n = !((en_req && ir_q.req && daisy_mode) ||
                       (en_err && ir_q.err && cfg_active) ||
                       (en_usr && ir_q.usr));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '{req: 1'b0, err: 1'b0, usr: 1'b0, irq_n: 1'b1};
        end else begin
            ir_q <= ir_d;
        end
    end

    assign irq_n    = ir_q.irq_n;
    assign req_flag = ir_q.req;
    assign err_flag = ir_q.err;
    assign usr_pend = ir_q.usr;

endmodule

// File: rtl/cfg_host_if.sv
module cfg_host_if
    import cfg_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_cs,
    input  logic              hst_wr,
    input  logic [1:0]        hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_ack,
    output logic              hst_irq_n,
    input  logic              cfg_done,
    input  logic              cfg_active,
    input  logic              cfg_daisy_mode,
    input  logic              cfg_data_req,
    input  logic              cfg_bs_err,
    input  logic [DATA_W-1:0] cfg_rd_data,
    output logic              cfg_wr_stb,
    output logic [DATA_W-1:0] cfg_wr_data,
    input  logic              usr_irq_n,
    output logic              usr_mode_en,
    output logic              ser_start,
    input  logic              ser_done
);

    ctrl_t             ctrl;
    logic              acc, data_access, status_read;
    logic              ser_busy, in_hold;
    logic              req_flag, err_flag, usr_pend;
    logic              hold_en, daisy_en, en_any;
    logic [STAT_W-1:0] status;

    assign daisy_en    = ctrl.daisy_out;
    assign hold_en     = ctrl.daisy_out && ctrl.bus_hold;
    assign en_any      = ctrl.en_req || ctrl.en_err || ctrl.en_usr;
    assign status      = {ser_busy, usr_pend, err_flag, req_flag};
    assign usr_mode_en = ctrl.usr_mode;

    chi_bus_ctrl u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (hst_cs),
        .wr       (hst_wr),
        .addr     (hst_addr),
        .hold_en  (hold_en),
        .daisy_en (daisy_en),
        .ser_done (ser_done),
        .acc      (acc),
        .ack      (hst_ack),
        .ser_busy (ser_busy),
        .in_hold  (in_hold)
    );

    chi_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .wr          (hst_wr),
        .addr        (hst_addr),
        .wdata       (hst_wdata),
        .cfg_done    (cfg_done),
        .status      (status),
        .cfg_rd_data (cfg_rd_data),
        .ctrl        (ctrl),
        .rdata       (hst_rdata),
        .wr_stb      (cfg_wr_stb),
        .wr_data     (cfg_wr_data),
        .ser_start   (ser_start),
        .data_access (data_access),
        .status_read (status_read)
    );

    chi_irq_ctrl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req      (ctrl.en_req),
        .en_err      (ctrl.en_err),
        .en_usr      (ctrl.en_usr),
        .daisy_mode  (cfg_daisy_mode),
        .cfg_active  (cfg_active),
        .data_req    (cfg_data_req),
        .bs_err      (cfg_bs_err),
        .usr_irq_n   (usr_irq_n),
        .data_access (data_access),
        .status_read (status_read),
        .irq_n       (hst_irq_n),
        .req_flag    (req_flag),
        .err_flag    (err_flag),
        .usr_pend    (usr_pend)
    );

endmodule

// File: rtl/chi_checker.sv
module chi_checker (
    input logic clk,
    input logic rst_n,
    input logic hst_ack,
    input logic hst_irq_n,
    input logic en_any,
    input logic in_hold,
    input logic ser_done,
    input logic ser_start,
    input logic daisy_en,
    input logic cfg_done,
    input logic usr_mode_en
);

    // R4: acknowledge never lasts two cycles
    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack);

    // R9: no interrupt without any enable in the previous cycle
    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_any) |-> hst_irq_n);

    // R10: a held transfer is only acknowledged after the serializer finished
    assert_hold_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_ack && $past(in_hold)) |-> $past(ser_done));

    // R11: serializer start only with daisy output enabled
    assert_ser_daisy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> $past(daisy_en));

    // R3: user-mode bit frozen once done is high
    assert_usr_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_done) |-> $stable(usr_mode_en));

endmodule

bind cfg_host_if chi_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hst_ack     (hst_ack),
    .hst_irq_n   (hst_irq_n),
    .en_any      (en_any),
    .in_hold     (in_hold),
    .ser_done    (ser_done),
    .ser_start   (ser_start),
    .daisy_en    (daisy_en),
    .cfg_done    (cfg_done),
    .usr_mode_en (usr_mode_en)
);

// File: tb/cfg_host_if_bench.sv
module cfg_host_if_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_cs = 1'b0;
    logic       hst_wr = 1'b0;
    logic [1:0] hst_addr = 2'd0;
    logic [7:0] hst_wdata = 8'h00;
    logic [7:0] hst_rdata;
    logic       hst_ack, hst_irq_n;
    logic       cfg_done = 1'b0, cfg_active = 1'b0, cfg_daisy_mode = 1'b0;
    logic       cfg_data_req = 1'b0, cfg_bs_err = 1'b0;
    logic [7:0] cfg_rd_data = 8'h00;
    logic       cfg_wr_stb;
    logic [7:0] cfg_wr_data;
    logic       usr_irq_n = 1'b1;
    logic       usr_mode_en, ser_start;
    logic       ser_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int ser_cnt = 0;
    logic [7:0] last_wr = 8'h00;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_host_if u_cfg_host_if (
        .clk(clk), .rst_n(rst_n), .hst_cs(hst_cs), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_ack(hst_ack), .hst_irq_n(hst_irq_n), .cfg_done(cfg_done),
        .cfg_active(cfg_active), .cfg_daisy_mode(cfg_daisy_mode),
        .cfg_data_req(cfg_data_req), .cfg_bs_err(cfg_bs_err),
        .cfg_rd_data(cfg_rd_data), .cfg_wr_stb(cfg_wr_stb),
        .cfg_wr_data(cfg_wr_data), .usr_irq_n(usr_irq_n),
        .usr_mode_en(usr_mode_en), .ser_start(ser_start), .ser_done(ser_done)
    );

    always @(negedge clk) begin
        if (cfg_wr_stb) begin
            stb_cnt++;
            last_wr = cfg_wr_data;
        end
        if (ser_start) ser_cnt++;
    end

    // {wr, addr, wdata, expected read}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 8'hA5, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'hA5},
        {1'b1, 2'd0, 8'h5A, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'h5A},
        {1'b1, 2'd0, 8'hFF, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'hFF},
        {1'b1, 2'd1, 8'hFF, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h3F},
        {1'b1, 2'd1, 8'h00, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h00},
        {1'b1, 2'd1, 8'h15, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h15},
        {1'b0, 2'd2, 8'h00, 8'h00},
        {1'b1, 2'd2, 8'hFF, 8'h00},
        {1'b0, 2'd2, 8'h00, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'hFF},
        {1'b1, 2'd1, 8'h00, 8'h00}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        hst_cs = 1'b1; hst_wr = w; hst_addr = a; hst_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!hst_ack && lat < 50);
        rd = hst_rdata;
        hst_cs = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] rd; int lat;
        access(1'b1, a, d, rd, lat);
        check(lat == 1, "R4 write latency", lat, 1);
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] rd; int lat;
        access(1'b0, a, 8'h00, rd, lat);
        check(rd == exp, tag, rd, exp);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=0x1 expected=0x0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lat, s0, c0, acks;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(hst_irq_n == 1'b1, "R9 reset irq", hst_irq_n, 1);
        check(hst_ack == 1'b0, "R4 reset ack", hst_ack, 0);
        check(usr_mode_en == 1'b0, "R2 reset user mode", usr_mode_en, 0);
        rd_reg(2'd0, 8'h00, "R1 reset scratch");
        rd_reg(2'd1, 8'h00, "R2 reset ctrl");

        // table walk: R1 scratch, R2 ctrl, R5 status writes ignored
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][18], VEC[i][17:16], VEC[i][15:8], rd, lat);
            check(lat == 1, "R4 table latency", lat, 1);
            if (!VEC[i][18]) begin
                if (VEC[i][17:16] == 2'd0) check(rd == VEC[i][7:0], "R1 scratch read", rd, VEC[i][7:0]);
                else if (VEC[i][17:16] == 2'd1) check(rd == VEC[i][7:0], "R2 ctrl read", rd, VEC[i][7:0]);
                else check(rd == VEC[i][7:0], "R5 status read", rd, VEC[i][7:0]);
            end
        end

        // R4: chip select held after acknowledge gives one ack only
        hst_cs = 1'b1; hst_wr = 1'b0; hst_addr = 2'd0;
        acks = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (hst_ack) acks++;
        end
        check(acks == 1, "R4 single ack while cs held", acks, 1);
        hst_cs = 1'b0;
        @(negedge clk);

        // R3: user mode lock
        wr_reg(2'd1, 8'h20);
        check(usr_mode_en == 1'b1, "R3 user mode set", usr_mode_en, 1);
        cfg_done = 1'b1;
        wr_reg(2'd1, 8'h01);
        rd_reg(2'd1, 8'h21, "R3 user mode kept after done");
        check(usr_mode_en == 1'b1, "R3 user mode pin kept", usr_mode_en, 1);
        cfg_done = 1'b0;
        wr_reg(2'd1, 8'h00);
        cfg_done = 1'b1;
        wr_reg(2'd1, 8'h20);
        rd_reg(2'd1, 8'h00, "R3 set ignored after done");
        cfg_done = 1'b0;

        // R8 / R9: user interrupt
        wr_reg(2'd1, 8'h04);
        usr_irq_n = 1'b0;
        @(negedge clk);
        check(hst_irq_n == 1'b1, "R9 irq not before two cycles", hst_irq_n, 1);
        @(negedge clk);
        check(hst_irq_n == 1'b0, "R8 user irq asserted", hst_irq_n, 0);
        rd_reg(2'd2, 8'h04, "R5 user pending status");
        usr_irq_n = 1'b1;
        repeat (2) @(negedge clk);
        check(hst_irq_n == 1'b1, "R8 user irq released", hst_irq_n, 1);
        wr_reg(2'd1, 8'h00);
        usr_irq_n = 1'b0;
        repeat (3) @(negedge clk);
        check(hst_irq_n == 1'b1, "R8 user irq disabled", hst_irq_n, 1);
        usr_irq_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: bitstream error
        wr_reg(2'd1, 8'h02);
        cfg_active = 1'b1;
        pulse(cfg_bs_err);
        @(negedge clk);
        check(hst_irq_n == 1'b0, "R7 error irq asserted", hst_irq_n, 0);
        cfg_active = 1'b0;
        repeat (2) @(negedge clk);
        check(hst_irq_n == 1'b1, "R7 error irq gated outside config", hst_irq_n, 1);
        cfg_active = 1'b1;
        repeat (2) @(negedge clk);
        check(hst_irq_n == 1'b0, "R7 error irq back in config", hst_irq_n, 0);
        rd_reg(2'd2, 8'h02, "R7 error status");
        check(hst_irq_n == 1'b1, "R7 status read clears irq", hst_irq_n, 1);
        rd_reg(2'd2, 8'h00, "R7 error flag cleared");
        cfg_active = 1'b0;
        pulse(cfg_bs_err);
        rd_reg(2'd2, 8'h00, "R7 error ignored outside config");

        // R6: data request
        wr_reg(2'd1, 8'h01);
        cfg_daisy_mode = 1'b1;
        pulse(cfg_data_req);
        @(negedge clk);
        check(hst_irq_n == 1'b0, "R6 data request irq", hst_irq_n, 0);
        rd_reg(2'd2, 8'h01, "R6 request status");
        cfg_rd_data = 8'h3C;
        rd_reg(2'd3, 8'h3C, "R12 config data read");
        check(hst_irq_n == 1'b1, "R6 data access clears irq", hst_irq_n, 1);
        rd_reg(2'd2, 8'h00, "R6 request flag cleared");
        cfg_daisy_mode = 1'b0;
        pulse(cfg_data_req);
        rd_reg(2'd2, 8'h00, "R6 request ignored outside daisy mode");

        // R12 / R11: immediate data writes
        wr_reg(2'd1, 8'h00);
        s0 = stb_cnt; c0 = ser_cnt;
        wr_reg(2'd3, 8'h81);
        check(stb_cnt == s0 + 1, "R12 write strobe", stb_cnt - s0, 1);
        check(last_wr == 8'h81, "R12 write byte", last_wr, 8'h81);
        check(ser_cnt == c0, "R11 no serializer without daisy", ser_cnt - c0, 0);
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd3, 8'h42);
        check(ser_cnt == c0, "R11 hold alone no serializer", ser_cnt - c0, 0);
        check(last_wr == 8'h42, "R12 write byte 2", last_wr, 8'h42);
        wr_reg(2'd1, 8'h08);
        wr_reg(2'd3, 8'h43);
        check(ser_cnt == c0 + 1, "R11 daisy starts serializer", ser_cnt - c0, 1);
        rd_reg(2'd2, 8'h08, "R11 serializer busy");
        pulse(ser_done);
        rd_reg(2'd2, 8'h00, "R11 serializer idle");

        // R10: held write
        wr_reg(2'd1, 8'h18);
        c0 = ser_cnt;
        hst_cs = 1'b1; hst_wr = 1'b1; hst_addr = 2'd3; hst_wdata = 8'h99;
        acks = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (hst_ack) acks++;
        end
        check(acks == 0, "R10 no ack while serializing", acks, 0);
        check(ser_cnt == c0 + 1, "R10 serializer started", ser_cnt - c0, 1);
        ser_done = 1'b1;
        @(negedge clk);
        ser_done = 1'b0;
        check(hst_ack == 1'b1, "R10 ack after serializer done", hst_ack, 1);
        hst_cs = 1'b0;
        @(negedge clk);
        check(hst_ack == 1'b0, "R10 ack single cycle", hst_ack, 0);
        check(last_wr == 8'h99, "R12 held write byte", last_wr, 8'h99);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule